// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block turns a fast reference clock into a slow core clock whose average frequency falls between two integer divide ratios. It divides by a first ratio for a programmed number of output periods. It then divides by a second ratio for another programmed number of periods, and it repeats this pattern without end. With a 24 MHz reference, first ratio 733, second ratio 732 and repeat counts 8 and 11, the long-run rate comes very close to 32.768 kHz. The block also has a plain single-ratio mode, a bypass that forwards the reference clock, and two enable bits. Both enable bits must be set before anything leaves the block.

Software programs two 32-bit configuration words. The recommended sequence is to drop the enables, load the ratios and counts, select dual mode and clear bypass, and then raise the enables again. Ratio, count and mode changes made while the divider runs are taken up only when the current output period ends, so no truncated pulse is produced. A two-bit status output tells which mode is in effect.

Top module: `frac_clk_div`

## Requirements
- R1: After reset with both configuration words zero, `clkOut` is low and `modeStat` is 0.
- R2: While word 0 bit 31 (input enable) or bit 30 (output enable) is clear, `clkOut` is held low and all counters are cleared. On the first clock edge with both enables set, a new period at the first ratio begins, with the repeat count at zero.
- R3: With word 0 bit 28 (dual) clear, every output period lasts N1 reference cycles. N1 is word 0 bits [11:0] plus one. The second ratio and the repeat counts have no effect.
- R4: With dual set, M1 periods of N1 cycles alternate with M2 periods of N2 cycles, starting with N1. N2 is word 0 bits [23:12] plus one. M1 is word 1 bits [11:0] plus one, and M2 is word 1 bits [23:12] plus one.
- R5: Within each period of N cycles, `clkOut` is high for the first floor(N/2) cycles and low for the rest.
- R6: With word 1 bit 24 (bypass) set and both enables set, `clkOut` equals `clkRef`.
- R7: A change to the ratios, the counts or the dual bit has no effect on the period in progress. It governs the period that starts at the next boundary, including a boundary on the very next edge.
- R8: `modeStat` is 0 when disabled, 3 in bypass, 2 when the current period runs in dual mode, and 1 in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkRef | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divCfg0 | input | 32 | Ratios, dual bit and enable bits |
| divCfg1 | input | 32 | Repeat counts and bypass bit |
| clkOut | output | 1 | Divided (or bypassed) clock |
| modeStat | output | 2 | Mode in effect (off/single/dual/bypass) |

## Verification
Two events can fall in the same cycle: a period boundary and a write to the configuration words. The bench writes new ratios in the middle of a period and also in the final cycle of a period. In the first case the running period must keep its old length. In the second case the new length must apply from the very next period. A reference model in the bench advances cycle by cycle and reads the configuration only at the boundaries it predicts, and it compares every sampled output bit against its own waveform.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int RATIO_W = 12;
  localparam int CNT_W   = 12;

  localparam int N1_LSB    = 0;
  localparam int N2_LSB    = 12;
  localparam int DUAL_BIT  = 28;
  localparam int OUTEN_BIT = 30;
  localparam int INEN_BIT  = 31;
  localparam int M1_LSB    = 0;
  localparam int M2_LSB    = 12;
  localparam int BYP_BIT   = 24;

  typedef struct packed {
    logic clear;    // enables dropped: hold everything at zero
    logic load;     // a new period starts on this edge
    logic selCur;   // running period uses the second ratio
    logic selNext;  // next period uses the second ratio
  } divStrobe_t;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_BYPASS = 2'd3
  } divMode_t;

  // number of high cycles for a ratio stored as (N - 1)
  function automatic logic [RATIO_W:0] halfPeriod(input logic [RATIO_W-1:0] ratioM1);
    return ({1'b0, ratioM1} + 1'b1) >> 1;
  endfunction
endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             dualCfg,
  input  logic [CNT_W-1:0] rep1Cfg,
  input  logic [CNT_W-1:0] rep2Cfg,
  input  logic             lastCyc,
  output divStrobe_t       strb
);
  logic             running;
  logic             phaseN2, nextPhase;
  logic [CNT_W-1:0] repDone, nextRep, curLimit;

  always_comb begin
    curLimit  = phaseN2 ? rep2Cfg : rep1Cfg;
    nextPhase = phaseN2;
    nextRep   = repDone;
    if (!running) begin
      nextPhase = 1'b0;
      nextRep   = '0;
    end else if (lastCyc) begin
      if (dualCfg) begin
        if (repDone >= curLimit) begin
          nextPhase = ~phaseN2;
          nextRep   = '0;
        end else begin
          nextRep = repDone + 1'b1;
        end
      end else begin
        nextPhase = 1'b0;
        nextRep   = '0;
      end
    end
  end

  always_comb begin
    strb.clear   = ~enable;
    strb.load    = enable & (~running | lastCyc);
    strb.selCur  = phaseN2;
    strb.selNext = nextPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phaseN2 <= 1'b0;
      repDone <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      phaseN2 <= 1'b0;
      repDone <= '0;
    end else begin
      running <= 1'b1;
      if (strb.load) begin
        phaseN2 <= nextPhase;
        repDone <= nextRep;
      end
    end
  end
endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratio1Cfg,
  input  logic [RATIO_W-1:0] ratio2Cfg,
  input  logic               dualCfg,
  input  divStrobe_t         strb,
  output logic               lastCyc,
  output logic               divOut,
  output logic               actDual
);
  logic [RATIO_W-1:0] cycCnt;
  logic [RATIO_W-1:0] actRatio1, actRatio2;
  logic [RATIO_W-1:0] curRatio, nextRatio;
  logic [RATIO_W:0]   cntPlusOne;

  assign curRatio   = strb.selCur  ? actRatio2 : actRatio1;
  assign nextRatio  = strb.selNext ? ratio2Cfg : ratio1Cfg;
  assign lastCyc    = (cycCnt == curRatio);
  assign cntPlusOne = {1'b0, cycCnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt    <= '0;
      actRatio1 <= '0;
      actRatio2 <= '0;
      actDual   <= 1'b0;
      divOut    <= 1'b0;
    end else if (strb.clear || strb.load) begin
      cycCnt    <= '0;
      actRatio1 <= ratio1Cfg;
      actRatio2 <= ratio2Cfg;
      actDual   <= dualCfg;
      divOut    <= strb.load && (halfPeriod(nextRatio) != '0);
    end else begin
      cycCnt <= cntPlusOne[RATIO_W-1:0];
      divOut <= (cntPlusOne < halfPeriod(curRatio));
    end
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
(
  input  logic        clkRef,
  input  logic        rstN,
  input  logic [31:0] divCfg0,
  input  logic [31:0] divCfg1,
  output logic        clkOut,
  output logic [1:0]  modeStat
);
  logic               enable, bypass, dualCfg;
  logic [RATIO_W-1:0] ratio1Cfg, ratio2Cfg;
  logic [CNT_W-1:0]   rep1Cfg, rep2Cfg;
  logic               lastCyc, divOut, actDual;
  divStrobe_t         strb;
  divMode_t           modeNow;

  assign ratio1Cfg = divCfg0[N1_LSB +: RATIO_W];
  assign ratio2Cfg = divCfg0[N2_LSB +: RATIO_W];
  assign dualCfg   = divCfg0[DUAL_BIT];
  assign enable    = divCfg0[INEN_BIT] & divCfg0[OUTEN_BIT];
  assign rep1Cfg   = divCfg1[M1_LSB +: CNT_W];
  assign rep2Cfg   = divCfg1[M2_LSB +: CNT_W];
  assign bypass    = divCfg1[BYP_BIT];

  fcd_ctrl u_ctrl (
    .clk     (clkRef),
    .rstN    (rstN),
    .enable  (enable),
    .dualCfg (dualCfg),
    .rep1Cfg (rep1Cfg),
    .rep2Cfg (rep2Cfg),
    .lastCyc (lastCyc),
    .strb    (strb)
  );

  fcd_datapath u_dp (
    .clk       (clkRef),
    .rstN      (rstN),
    .ratio1Cfg (ratio1Cfg),
    .ratio2Cfg (ratio2Cfg),
    .dualCfg   (dualCfg),
    .strb      (strb),
    .lastCyc   (lastCyc),
    .divOut    (divOut),
    .actDual   (actDual)
  );

  always_comb begin
    if (!enable)     modeNow = MODE_OFF;
    else if (bypass) modeNow = MODE_BYPASS;
    else if (actDual) modeNow = MODE_DUAL;
    else             modeNow = MODE_SINGLE;
  end

  assign modeStat = modeNow;
  assign clkOut   = enable & (bypass ? clkRef : divOut);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
(
  input logic        clkRef,
  input logic        rstN,
  input logic [31:0] divCfg0,
  input logic [31:0] divCfg1,
  input logic        clkOut,
  input logic [1:0]  modeStat
);
  localparam int MAX_HIGH = (1 << RATIO_W) / 2;

  logic en, byp;
  logic [RATIO_W:0] highRun;

  assign en  = divCfg0[INEN_BIT] & divCfg0[OUTEN_BIT];
  assign byp = divCfg1[BYP_BIT];

  always_ff @(posedge clkRef or negedge rstN) begin
    if (!rstN)                       highRun <= '0;
    else if (en && !byp && clkOut)   highRun <= highRun + 1'b1;
    else                             highRun <= '0;
  end

  a_r2_gated_low: assert property (@(posedge clkRef) disable iff (!rstN)
    !en |-> !clkOut);

  a_r8_off_status: assert property (@(posedge clkRef) disable iff (!rstN)
    !en |-> modeStat == 2'd0);

  a_r6_bypass_status: assert property (@(posedge clkRef) disable iff (!rstN)
    (en && byp) |-> modeStat == 2'd3);

  a_r8_divide_status: assert property (@(posedge clkRef) disable iff (!rstN)
    (en && !byp) |-> (modeStat == 2'd1 || modeStat == 2'd2));

  a_r2_fresh_start: assert property (@(posedge clkRef) disable iff (!rstN)
    (!en ##1 (en && divCfg0[N1_LSB +: RATIO_W] != '0)) |=> (!en || byp || clkOut));

  a_r5_high_bound: assert property (@(posedge clkRef) disable iff (!rstN)
    (en && !byp && clkOut) |-> highRun < MAX_HIGH);
endmodule

bind frac_clk_div fcd_checker u_chk (
  .clkRef   (clkRef),
  .rstN     (rstN),
  .divCfg0  (divCfg0),
  .divCfg1  (divCfg1),
  .clkOut   (clkOut),
  .modeStat (modeStat)
);

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfg0 = '0;
  logic [31:0] cfg1 = '0;
  logic        clkOut;
  logic [1:0]  modeStat;

  int total = 0;
  int bad   = 0;

  // bench-side configuration (full values, not minus one)
  int bN1, bN2, bM1, bM2, bDual;
  // reference model state
  int mIdx, mCurN, mPhase, mRep;

  frac_clk_div uut (
    .clkRef   (clk),
    .rstN     (rstN),
    .divCfg0  (cfg0),
    .divCfg1  (cfg1),
    .clkOut   (clkOut),
    .modeStat (modeStat)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(input int n1, input int n2, input int m1, input int m2,
                        input int dual, input int inE, input int outE, input int byp);
    bN1 = n1; bN2 = n2; bM1 = m1; bM2 = m2; bDual = dual;
    cfg0 = 32'((n1 - 1) & 12'hFFF) | (32'((n2 - 1) & 12'hFFF) << 12) |
           (32'(dual) << 28) | (32'(outE) << 30) | (32'(inE) << 31);
    cfg1 = 32'((m1 - 1) & 12'hFFF) | (32'((m2 - 1) & 12'hFFF) << 12) | (32'(byp) << 24);
  endtask

  task automatic modelStart();
    mIdx = -1;
  endtask

  task automatic modelStep();
    if (mIdx < 0) begin
      mPhase = 0; mRep = 0; mCurN = bN1; mIdx = 0;
    end else begin
      mIdx++;
      if (mIdx == mCurN) begin
        mIdx = 0;
        if (bDual != 0) begin
          mRep++;
          if (mRep >= (mPhase != 0 ? bM2 : bM1)) begin
            mPhase = 1 - mPhase;
            mRep = 0;
          end
        end else begin
          mPhase = 0; mRep = 0;
        end
        mCurN = (mPhase != 0) ? bN2 : bN1;
      end
    end
  endtask

  // one check per call: every sampled bit must follow the model
  task automatic runWave(input int cycles, input string tag);
    int firstBad = -1;
    int actBit = 0, expBit = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      modelStep();
      if (firstBad < 0 && (clkOut !== (mIdx < mCurN / 2))) begin
        firstBad = i;
        actBit = int'(clkOut);
        expBit = (mIdx < mCurN / 2) ? 1 : 0;
      end
    end
    if (firstBad >= 0) $display("  mismatch at sample %0d", firstBad);
    check(firstBad < 0, tag, actBit, expBit);
  endtask

  task automatic disableAll();
    @(negedge clk);
    setCfg(1, 1, 1, 1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(clkOut == 1'b0, "R1 clkOut after reset", int'(clkOut), 0);
    check(modeStat == 2'd0, "R1 R8 modeStat after reset", int'(modeStat), 0);
  endtask

  task automatic t_single();
    @(negedge clk);
    setCfg(6, 3, 2, 2, 0, 1, 1, 0);
    modelStart();
    runWave(40, "R3 single ratio 6 wave");
    check(modeStat == 2'd1, "R8 single status", int'(modeStat), 1);
    disableAll();
    @(negedge clk);
    setCfg(7, 2, 1, 1, 0, 1, 1, 0);
    modelStart();
    runWave(35, "R5 odd ratio 7 duty");
  endtask

  task automatic t_dual();
    disableAll();
    @(negedge clk);
    setCfg(5, 4, 2, 3, 1, 1, 1, 0);
    modelStart();
    runWave(90, "R4 dual 5/4 counts 2/3");
    check(modeStat == 2'd2, "R8 dual status", int'(modeStat), 2);
  endtask

  task automatic t_default();
    disableAll();
    @(negedge clk);
    setCfg(733, 732, 8, 11, 1, 1, 1, 0);
    modelStart();
    runWave(8 * 733 + 11 * 732 + 1500, "R4 R5 default 733/732 8/11");
  endtask

  task automatic t_gate();
    int highSeen = 0;
    disableAll();
    @(negedge clk);
    setCfg(5, 4, 2, 3, 1, 1, 1, 0);
    modelStart();
    runWave(13, "R4 before gating");
    // clear only the input enable in mid pattern
    cfg0[31] = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (clkOut !== 1'b0) highSeen++;
    end
    check(highSeen == 0, "R2 output low while input enable clear", highSeen, 0);
    check(modeStat == 2'd0, "R2 R8 status while gated", int'(modeStat), 0);
    cfg0[31] = 1'b1;
    modelStart();
    runWave(60, "R2 restart at first ratio");
  endtask

  task automatic t_midchange();
    disableAll();
    @(negedge clk);
    setCfg(8, 8, 1, 1, 0, 1, 1, 0);
    modelStart();
    runWave(3, "R7 lead-in");
    setCfg(4, 8, 1, 1, 0, 1, 1, 0);
    runWave(30, "R7 change mid period");
    while (mIdx != mCurN - 1) runWave(1, "R7 align");
    setCfg(6, 8, 1, 1, 0, 1, 1, 0);
    runWave(30, "R7 change in last cycle");
    while (mIdx != 2) runWave(1, "R7 align dual");
    setCfg(6, 3, 1, 2, 1, 1, 1, 0);
    runWave(40, "R7 R4 dual switched on mid period");
  endtask

  task automatic t_bypass();
    int badHi = 0, badLo = 0;
    disableAll();
    @(negedge clk);
    setCfg(5, 4, 2, 3, 1, 1, 1, 1);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #2;
      if (clkOut !== 1'b1) badHi++;
      @(negedge clk); #2;
      if (clkOut !== 1'b0) badLo++;
    end
    check(badHi == 0, "R6 bypass high phase", badHi, 0);
    check(badLo == 0, "R6 bypass low phase", badLo, 0);
    check(modeStat == 2'd3, "R6 R8 bypass status", int'(modeStat), 3);
    cfg0[30] = 1'b0;
    #1;
    check(clkOut == 1'b0, "R2 bypass gated by output enable", int'(clkOut), 0);
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    setCfg(1, 1, 1, 1, 0, 0, 0, 0);
    cfg0 = '0;
    cfg1 = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_default();
    t_gate();
    t_midchange();
    t_bypass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule